// File: doc/BRIEF.md
# Byte-Level Open-Drain I2C Master Engine

This block drives a two-wire I2C bus one primitive at a time. A host hands it a single command (bus start condition, bus stop condition, byte transmit, byte receive, or acknowledge transmit) and waits for a one-cycle completion pulse before issuing the next. The clock and data lines are open-drain: an output of 1 means the line is released and an output of 0 means the line is pulled low. The data line is also read back through a two-flop synchroniser to collect received bits and the receiver's acknowledge.

Every phase of every primitive lasts a whole number of delay units. One delay unit is a programmable number of system clock cycles. Phases have unequal lengths: a receive bit holds the clock high for longer than a transmit bit does. The engine also keeps a bus-busy flag and a three-valued acknowledge register. A host read strobe returns that register to its invalid value.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, scl_o and sda_o are 1 (released), ready is 1, done is 0, busy is 0 and ack_state is 2'b00 (invalid).
- R2: Start (cmd_op 3'd1) sets sda_o to 1 for 2 units, then scl_o to 1 for 2 units, then sda_o to 0 for 2 units, then scl_o to 0 for 1 unit. busy becomes 1 together with done.
- R3: Stop (cmd_op 3'd2) sets sda_o to 0 for 2 units, then scl_o to 1 for 2 units, then sda_o to 1 for 2 units. busy becomes 0 together with done.
- R4: Byte transmit (cmd_op 3'd3) sends cmd_data MSB first. Each bit sets sda_o for 2 units, holds scl_o at 1 for 2 units, then holds scl_o at 0 for 1 unit. Then sda_o is released for 2 units, scl_o is high for 2 units and low for 1 unit, for 45 units in total.
- R5: At the end of a transmit's ninth clock-high phase, the synchronised sda_i is sampled: low sets ack_state to 2'b01 (ACK) and high sets it to 2'b10 (NAK). Accepting a start, a stop or a transmit sets ack_state to 2'b00. The value 2'b11 never appears.
- R6: Byte receive (cmd_op 3'd4) releases sda_o for 2 units. Then, for each of 8 bits, it holds scl_o high for 3 units, shifts the synchronised sda_i into the LSB of a left-shifting register, and holds scl_o low for 2 units (42 units in total). rd_data carries the byte from the cycle in which done is 1.
- R7: Acknowledge transmit (cmd_op 3'd5) sets sda_o to cmd_data[0] for 2 units (0 = ACK, 1 = NAK), then scl_o to 1 for 2 units, then scl_o to 0 for 2 units.
- R8: In a cycle where ack_rd is 1, ack_state shows the value held so far. In the next cycle ack_state is 2'b00, unless a transmit samples an acknowledge at that same edge.
- R9: One delay unit is trim clock cycles, and a trim of 0 counts as 1 cycle. done rises exactly (total units × unit length) cycles after the edge that accepts the command.
- R10: A command is accepted on a rising edge where cmd_valid is 1, ready is 1 and cmd_op is one of 3'd1 to 3'd5. ready stays 0 until done, and done is a single-cycle pulse. Commands presented while ready is 0 are ignored, and so are opcodes 3'd0, 3'd6 and 3'd7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trim | input | TRIM_W | Delay-unit length in clock cycles (0 treated as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Primitive code: 1 start, 2 stop, 3 transmit, 4 receive, 5 acknowledge |
| cmd_data | input | 8 | Byte to transmit; bit 0 is the acknowledge level for opcode 5 |
| ready | output | 1 | Engine idle and able to accept a command |
| done | output | 1 | One-cycle pulse when a primitive's final wait ends |
| rd_data | output | 8 | Last received byte, updated with done |
| ack_rd | input | 1 | Read strobe for the acknowledge register |
| ack_state | output | 2 | Acknowledge register: 00 invalid, 01 ACK, 10 NAK |
| busy | output | 1 | Bus owned between a start and a stop |
| scl_o | output | 1 | Clock line, 1 = released, 0 = pulled low |
| sda_o | output | 1 | Data line, 1 = released, 0 = pulled low |
| sda_i | input | 1 | Data line level as seen on the bus |

## Verification
The engine accepts a command on a rising edge. done, ready, busy, ack_state and rd_data change on the edge exactly (total units × unit length) cycles after that, and a read strobe clears ack_state one edge after the cycle it is seen in. The bench applies stimulus at falling edges and samples at every falling edge after the accepting edge. It compares the observed scl_o/sda_o pattern against a phase-by-phase waveform built from the requirements, and checks that done first appears at index units × unit length + 1. Bit changes from the bench's bus-side model happen on falling edges of the clock line, so each bit is stable for far longer than the two-cycle synchroniser delay before the engine samples it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int PH_W   = 3;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_STOP  = 3'd2,
        OP_WRITE = 3'd3,
        OP_READ  = 3'd4,
        OP_ACK   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ACK_INVALID = 2'b00,
        ACK_OK      = 2'b01,
        ACK_NAK     = 2'b10
    } ack_e;

    typedef enum logic [2:0] {
        ACT_SDA_REL,
        ACT_SDA_LOW,
        ACT_SCL_REL,
        ACT_SCL_LOW,
        ACT_SDA_TX,
        ACT_SDA_ACKBIT
    } act_e;

    typedef enum logic [1:0] {
        SMP_NONE,
        SMP_ACK,
        SMP_BIT
    } smp_e;

    typedef struct packed {
        act_e            act;
        logic [1:0]      units;
        smp_e            smp;
        logic            loop;
        logic [PH_W-1:0] loop_to;
        logic            last;
    } step_t;

    function automatic logic op_legal(logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd5);
    endfunction

    function automatic step_t step_of(op_e op, logic [PH_W-1:0] ph);
        step_t s;
        s = '{ACT_SDA_REL, 2'd1, SMP_NONE, 1'b0, PH_W'(0), 1'b1};
        case (op)
            OP_START: case (ph)
                3'd0: s = '{ACT_SDA_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd1: s = '{ACT_SCL_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd2: s = '{ACT_SDA_LOW, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                default: s = '{ACT_SCL_LOW, 2'd1, SMP_NONE, 1'b0, PH_W'(0), 1'b1};
            endcase
            OP_STOP: case (ph)
                3'd0: s = '{ACT_SDA_LOW, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd1: s = '{ACT_SCL_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                default: s = '{ACT_SDA_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b1};
            endcase
            OP_WRITE: case (ph)
                3'd0: s = '{ACT_SDA_TX,  2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd1: s = '{ACT_SCL_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd2: s = '{ACT_SCL_LOW, 2'd1, SMP_NONE, 1'b1, PH_W'(0), 1'b0};
                3'd3: s = '{ACT_SDA_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd4: s = '{ACT_SCL_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                default: s = '{ACT_SCL_LOW, 2'd1, SMP_ACK, 1'b0, PH_W'(0), 1'b1};
            endcase
            OP_READ: case (ph)
                3'd0: s = '{ACT_SDA_REL, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd1: s = '{ACT_SCL_REL, 2'd3, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                default: s = '{ACT_SCL_LOW, 2'd2, SMP_BIT, 1'b1, PH_W'(1), 1'b1};
            endcase
            OP_ACK: case (ph)
                3'd0: s = '{ACT_SDA_ACKBIT, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                3'd1: s = '{ACT_SCL_REL,    2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b0};
                default: s = '{ACT_SCL_LOW, 2'd2, SMP_NONE, 1'b0, PH_W'(0), 1'b1};
            endcase
            default: s = '{ACT_SDA_REL, 2'd1, SMP_NONE, 1'b0, PH_W'(0), 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk) begin
        if (rst) ff_q <= '1;
        else     ff_q <= {ff_q[STAGES-2:0], d};
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/i2cm_unit_timer.sv
module i2cm_unit_timer #(
    parameter int TRIM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [TRIM_W-1:0] trim,
    output logic              tick
);
    logic [TRIM_W-1:0] cnt_q;
    logic [TRIM_W-1:0] unit_len;

    assign unit_len = (trim == '0) ? TRIM_W'(1) : trim;
    assign tick     = run && (cnt_q == TRIM_W'(1));

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= TRIM_W'(1);
        else if (restart || tick) cnt_q <= unit_len;
        else if (run)             cnt_q <= cnt_q - TRIM_W'(1);
    end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              ack_rd,
    input  logic              sda_s,
    input  logic              tick,
    output logic              run,
    output logic              restart,
    output logic              ready,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data,
    output logic [1:0]        ack_state,
    output logic              busy,
    output logic              scl_o,
    output logic              sda_o
);
    logic              run_q, done_q, busy_q, scl_q, sda_q;
    op_e               op_q, op_n;
    logic [PH_W-1:0]   ph_q, ph_n;
    logic [BIT_W-1:0]  bit_q, bit_n;
    logic [1:0]        unit_q;
    logic [BYTE_W-1:0] sh_q, sh_n, rd_q;
    ack_e              ack_q;
    step_t             cur, nxt;
    logic              accept, ph_end, enter, finish, wr_shift;
    logic              scl_n, sda_n;

    always_comb begin
        accept   = cmd_valid && !run_q && op_legal(cmd_op);
        cur      = step_of(op_q, ph_q);
        ph_end   = run_q && tick && (unit_q == 2'd1);
        enter    = 1'b0;
        finish   = 1'b0;
        wr_shift = 1'b0;
        op_n     = op_q;
        ph_n     = ph_q;
        bit_n    = bit_q;
        if (accept) begin
            enter = 1'b1;
            op_n  = op_e'(cmd_op);
            ph_n  = '0;
            bit_n = '0;
        end else if (ph_end) begin
            if (cur.loop && (bit_q != BIT_LAST)) begin
                enter    = 1'b1;
                ph_n     = cur.loop_to;
                bit_n    = bit_q + BIT_W'(1);
                wr_shift = (op_q == OP_WRITE);
            end else if (cur.last) begin
                finish = 1'b1;
            end else begin
                enter = 1'b1;
                ph_n  = ph_q + PH_W'(1);
            end
        end
        nxt = step_of(op_n, ph_n);

        sh_n = sh_q;
        if (accept)
            sh_n = cmd_data;
        else if (wr_shift)
            sh_n = {sh_q[BYTE_W-2:0], 1'b0};
        else if (enter && (nxt.smp == SMP_BIT))
            sh_n = {sh_q[BYTE_W-2:0], sda_s};

        scl_n = scl_q;
        sda_n = sda_q;
        if (enter) begin
            case (nxt.act)
                ACT_SDA_REL:    sda_n = 1'b1;
                ACT_SDA_LOW:    sda_n = 1'b0;
                ACT_SCL_REL:    scl_n = 1'b1;
                ACT_SCL_LOW:    scl_n = 1'b0;
                ACT_SDA_TX:     sda_n = sh_n[BYTE_W-1];
                ACT_SDA_ACKBIT: sda_n = sh_n[0];
                default:        sda_n = sda_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            op_q   <= OP_NONE;
            ph_q   <= '0;
            bit_q  <= '0;
            unit_q <= 2'd1;
            sh_q   <= '0;
            rd_q   <= '0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            ack_q  <= ACK_INVALID;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            op_q   <= op_n;
            ph_q   <= ph_n;
            bit_q  <= bit_n;
            sh_q   <= sh_n;
            scl_q  <= scl_n;
            sda_q  <= sda_n;
            done_q <= finish;
            if (accept)      run_q <= 1'b1;
            else if (finish) run_q <= 1'b0;
            if (enter)                unit_q <= nxt.units;
            else if (run_q && tick)   unit_q <= unit_q - 2'd1;
            if (finish && (op_q == OP_READ)) rd_q <= sh_q;
            if (finish && (op_q == OP_START)) busy_q <= 1'b1;
            else if (finish && (op_q == OP_STOP)) busy_q <= 1'b0;
            if (accept && (cmd_op == OP_START || cmd_op == OP_STOP || cmd_op == OP_WRITE))
                ack_q <= ACK_INVALID;
            else if (enter && (nxt.smp == SMP_ACK))
                ack_q <= sda_s ? ACK_NAK : ACK_OK;
            else if (ack_rd)
                ack_q <= ACK_INVALID;
        end
    end

    assign run       = run_q;
    assign restart   = accept;
    assign ready     = !run_q;
    assign done      = done_q;
    assign rd_data   = rd_q;
    assign ack_state = ack_q;
    assign busy      = busy_q;
    assign scl_o     = scl_q;
    assign sda_o     = sda_q;
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int TRIM_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TRIM_W-1:0] trim,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              ready,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ack_rd,
    output logic [1:0]        ack_state,
    output logic              busy,
    output logic              scl_o,
    output logic              sda_o,
    input  logic              sda_i
);
    logic sda_s, tick, run, restart;

    i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_i),
        .q   (sda_s)
    );

    i2cm_unit_timer #(.TRIM_W(TRIM_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .trim    (trim),
        .tick    (tick)
    );

    i2cm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .ack_rd    (ack_rd),
        .sda_s     (sda_s),
        .tick      (tick),
        .run       (run),
        .restart   (restart),
        .ready     (ready),
        .done      (done),
        .rd_data   (rd_data),
        .ack_state (ack_state),
        .busy      (busy),
        .scl_o     (scl_o),
        .sda_o     (sda_o)
    );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       ready,
    input logic       done,
    input logic       ack_rd,
    input logic [1:0] ack_state,
    input logic       busy,
    input logic       scl_o,
    input logic       sda_o
);
    logic [2:0] op_c;
    logic       legal_acc, byte_op;

    assign legal_acc = cmd_valid && ready && (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
    assign byte_op   = (op_c == 3'd3) || (op_c == 3'd4) || (op_c == 3'd5);

    always_ff @(posedge clk) begin
        if (rst)            op_c <= 3'd0;
        else if (legal_acc) op_c <= cmd_op;
    end

    p_idle_lines_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ready && !cmd_valid) |=> ($stable(scl_o) && $stable(sda_o)));

    p_accept_drops_ready_r10: assert property (@(posedge clk) disable iff (rst)
        legal_acc |=> !ready);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_with_ready_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);

    p_ack_clear_on_read_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && ready) |=> (ack_state == 2'b00));

    p_ack_legal_r5: assert property (@(posedge clk) disable iff (rst)
        ack_state != 2'b11);

    p_ack_start_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (legal_acc && (cmd_op <= 3'd3)) |=> (ack_state == 2'b00));

    p_busy_moves_on_done_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(busy) |-> done);

    p_sda_quiet_scl_high_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && byte_op && !ready && scl_o && $past(scl_o)) |-> $stable(sda_o));
endmodule

bind i2c_cmd_master i2cm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .ready     (ready),
    .done      (done),
    .ack_rd    (ack_rd),
    .ack_state (ack_state),
    .busy      (busy),
    .scl_o     (scl_o),
    .sda_o     (sda_o)
);

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] trim = 16'd2;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_data = 8'd0;
    logic        ready, done, busy, scl_o, sda_o, sda_i;
    logic [7:0]  rd_data;
    logic        ack_rd = 1'b0;
    logic [1:0]  ack_state;

    int n_checks = 0;
    int n_fail   = 0;

    // bus-side model
    logic       slv_rd_en = 1'b0;
    logic [7:0] slv_byte  = 8'h00;
    logic       slv_ack   = 1'b1;
    int         scl_falls = 0;
    int         slv_base  = 0;

    always #10 clk = ~clk;

    always @(negedge scl_o) scl_falls <= scl_falls + 1;

    assign sda_i = sda_o & (slv_rd_en ? slv_byte[3'(7 - (scl_falls - slv_base))] : slv_ack);

    i2c_cmd_master u0 (
        .clk(clk), .rst(rst), .trim(trim), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .ready(ready), .done(done), .rd_data(rd_data),
        .ack_rd(ack_rd), .ack_state(ack_state), .busy(busy), .scl_o(scl_o),
        .sda_o(sda_o), .sda_i(sda_i)
    );

    // expected waveform built from the requirements
    bit m_scl = 1'b1;
    bit m_sda = 1'b1;
    bit exp_scl [0:511];
    bit exp_sda [0:511];
    int exp_len;
    int unit_cyc;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic add_ph(input bit on_sda, input bit v, input int units);
        if (on_sda) m_sda = v; else m_scl = v;
        for (int i = 0; i < units * unit_cyc; i++) begin
            exp_scl[exp_len] = m_scl;
            exp_sda[exp_len] = m_sda;
            exp_len++;
        end
    endtask

    task automatic build(input logic [2:0] op, input logic [7:0] data);
        exp_len  = 0;
        unit_cyc = (trim == 16'd0) ? 1 : int'(trim);
        case (op)
            3'd1: begin add_ph(1, 1, 2); add_ph(0, 1, 2); add_ph(1, 0, 2); add_ph(0, 0, 1); end
            3'd2: begin add_ph(1, 0, 2); add_ph(0, 1, 2); add_ph(1, 1, 2); end
            3'd3: begin
                for (int b = 7; b >= 0; b--) begin
                    add_ph(1, data[b], 2); add_ph(0, 1, 2); add_ph(0, 0, 1);
                end
                add_ph(1, 1, 2); add_ph(0, 1, 2); add_ph(0, 0, 1);
            end
            3'd4: begin
                add_ph(1, 1, 2);
                for (int b = 0; b < 8; b++) begin add_ph(0, 1, 3); add_ph(0, 0, 2); end
            end
            default: begin add_ph(1, data[0], 2); add_ph(0, 1, 2); add_ph(0, 0, 2); end
        endcase
    endtask

    // issue one command, compare the line waveform and the completion timing
    task automatic run_cmd(input logic [2:0] op, input logic [7:0] data,
                           input string req, input bit inject);
        int cyc, mism;
        build(op, data);
        @(negedge clk);
        cmd_op = op; cmd_data = data; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1; mism = 0;
        while (!done && cyc < 1000) begin
            if (cyc - 1 < exp_len) begin
                if (scl_o !== exp_scl[cyc-1] || sda_o !== exp_sda[cyc-1]) mism++;
            end else mism++;
            if (inject && cyc == 5) begin cmd_op = 3'd2; cmd_valid = 1'b1; end
            if (inject && cyc == 7) cmd_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check(cyc - 1 == exp_len, req, "R9 cycles from accept to done", cyc - 1, exp_len);
        check(mism == 0, req, "line waveform mismatches", mism, 0);
        check(ready == 1'b1, req, "R10 ready with done", int'(ready), 1);
        @(negedge clk);
        check(done == 1'b0, req, "R10 done single pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        check(scl_o == 1'b1 && sda_o == 1'b1, "R1", "lines released", {scl_o, sda_o}, 3);
        check(ready == 1'b1 && done == 1'b0, "R1", "ready/done", {ready, done}, 2);
        check(busy == 1'b0 && ack_state == 2'b00, "R1", "busy/ack", {busy, ack_state}, 0);
    endtask

    task automatic t_start_write_ack();
        trim = 16'd2;
        run_cmd(3'd1, 8'h00, "R2", 1'b0);
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        slv_ack = 1'b0;
        run_cmd(3'd3, 8'hA5, "R4", 1'b0);
        check(ack_state == 2'b01, "R5", "ack after low sample", ack_state, 1);
        // R8: read strobe returns the held value, clears next cycle
        @(negedge clk); ack_rd = 1'b1;
        check(ack_state == 2'b01, "R8", "value during read", ack_state, 1);
        @(negedge clk); ack_rd = 1'b0;
        check(ack_state == 2'b00, "R8", "cleared after read", ack_state, 0);
    endtask

    task automatic t_nak_restart();
        trim = 16'd3;
        slv_ack = 1'b1;
        run_cmd(3'd3, 8'h3C, "R4", 1'b0);
        check(ack_state == 2'b10, "R5", "nak after high sample", ack_state, 2);
        run_cmd(3'd1, 8'h00, "R2", 1'b0);
        check(ack_state == 2'b00, "R5", "start clears ack", ack_state, 0);
    endtask

    task automatic t_read();
        trim = 16'd2;
        slv_byte = 8'hC6; slv_base = scl_falls; slv_rd_en = 1'b1;
        run_cmd(3'd4, 8'h00, "R6", 1'b0);
        slv_rd_en = 1'b0;
        check(rd_data == 8'hC6, "R6", "received byte", rd_data, 8'hC6);
        trim = 16'd1;
        slv_byte = 8'h5A; slv_base = scl_falls; slv_rd_en = 1'b1;
        run_cmd(3'd4, 8'hFF, "R6", 1'b0);
        slv_rd_en = 1'b0;
        check(rd_data == 8'h5A, "R6", "received byte short unit", rd_data, 8'h5A);
    endtask

    task automatic t_send_ack();
        trim = 16'd2;
        run_cmd(3'd5, 8'h00, "R7", 1'b0);
        run_cmd(3'd5, 8'h01, "R7", 1'b0);
    endtask

    task automatic t_ignore();
        trim = 16'd1;
        slv_ack = 1'b0;
        run_cmd(3'd3, 8'h81, "R10", 1'b1);
        check(busy == 1'b1, "R10", "stop during run ignored", int'(busy), 1);
        @(negedge clk); cmd_op = 3'd7; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        check(ready == 1'b1, "R10", "illegal opcode not accepted", int'(ready), 1);
        check(scl_o == m_scl && sda_o == m_sda, "R10", "lines after illegal opcode",
              {scl_o, sda_o}, {m_scl, m_sda});
    endtask

    task automatic t_stop();
        trim = 16'd2;
        run_cmd(3'd2, 8'h00, "R3", 1'b0);
        check(busy == 1'b0, "R3", "busy cleared by stop", int'(busy), 0);
    endtask

    task automatic t_trim_edges();
        trim = 16'd0;
        run_cmd(3'd1, 8'h00, "R9", 1'b0);
        run_cmd(3'd2, 8'h00, "R9", 1'b0);
        trim = 16'd4;
        run_cmd(3'd1, 8'h00, "R9", 1'b0);
        run_cmd(3'd2, 8'h00, "R3", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start_write_ack();
        t_nak_restart();
        t_read();
        t_send_ack();
        t_ignore();
        t_stop();
        t_trim_edges();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule